// File: doc/BRIEF.md
# I2C Slave Register-Access Front End for a Dual UART

This block is the I2C-bus slave that lets a host reach the register file of a two-channel UART. It watches the serial clock and data lines, finds START and STOP conditions, and decides from the first byte of each transfer whether it is being addressed. Its own 7-bit address is not a parameter fixed at build time. It comes from two strap pins. Each pin can be tied high, tied low, tied to the clock line or tied to the data line, so one design can answer on sixteen addresses.

After a write-direction address, the next byte is a subaddress. The block splits it into a channel number and a register index and keeps it. Each further byte of that write goes to the same register through a one-cycle write strobe. A repeated START followed by the read-direction address makes the block return data from the stored register. It fetches that data with a one-cycle read strobe and sends one byte for every master ACK, stopping at the master's NACK.

The controller has ten states:
- IDLE: the bus is free.
- ADDR: the address byte is arriving.
- ADDR_ACK: the address acknowledge clock.
- SUB: the subaddress byte is arriving.
- SUB_ACK: the subaddress acknowledge clock.
- WDATA: a write data byte is arriving.
- WDATA_ACK: the write data acknowledge clock.
- RDATA: the slave is shifting a read byte out.
- RACK: the master's acknowledge clock after a read byte.
- IGNORE: the slave is deaf until the next START.

A START moves any state to ADDR, and a STOP moves any state to IDLE. The normal path moves on at the falling SCL edge that closes each byte or acknowledge clock:
- ADDR goes to ADDR_ACK on a match and to IGNORE on a mismatch.
- ADDR_ACK goes to SUB for a write and to RDATA for a read.
- SUB goes to SUB_ACK, then to WDATA.
- WDATA goes to WDATA_ACK, which returns to WDATA.
- RDATA goes to RACK.
- RACK returns to RDATA after a master ACK and goes to IGNORE after a NACK.

Top module: `i2c_regbridge`

## Requirements
- R1: The 7-bit slave address is 0x48 + 4·c1 + c0. Here c1 is the level code of strap_i[1] and c0 is the level code of strap_i[0], with tied high = 0, tied low = 1, follows SCL = 2 and follows SDA = 3. With both pins tied high, the write address byte is 0x90.
- R2: When the address byte matches, the block pulls SDA low (sda_oe = 1) during the ninth clock. It asserts the drive only while SCL is low.
- R3: When the address byte does not match, the block never drives SDA and gives no strobe until the next START.
- R4: On a write, the byte after the address is acknowledged and held as the subaddress. Its bits 2:1 appear on reg_chan and its bits 6:3 appear on reg_idx. Bits 0 and 7 change nothing.
- R5: Every data byte after the subaddress is acknowledged. Each one gives one reg_wr pulse with the byte on reg_wdata, always to the same channel and index. The pulse comes while SCL is low.
- R6: A repeated START followed by the read address returns reg_rdata of the stored subaddress, MSB first. Each byte sent is preceded by one reg_rd pulse.
- R7: The block sends another byte after each master ACK (SDA low). After a master NACK it leaves SDA released until the next START.
- R8: A START or STOP in the middle of a byte abandons that byte, and no write strobe is given for it.
- R9: While reset is held, sda_oe, reg_wr and reg_rd are all 0.
- R10: reg_wr and reg_rd each last exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| strap_i | input | 2 | Address strap pins ([1] high-order pin) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_chan | output | 2 | Channel field of the stored subaddress |
| reg_idx | output | 4 | Register index field of the stored subaddress |
| reg_wdata | output | 8 | Write data to the register file |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data from the register file, valid before the next SCL fall |

## Verification
The bench sweeps all sixteen strap combinations. For each one it sends the matching address, a deliberately wrong address, a write burst and a read burst.

The matching and wrong addresses separate a correct level decoder from one that swaps or merges levels. The subaddress in each pass sets bits 0 and 7 to different values, which shows that they are ignored and that the channel and index fields are not shifted. The read burst ends with a NACK followed by one extra clocked bit, which shows that the slave really lets go of the bus. Separate runs place a START and then a STOP in the middle of a data byte, to show that a partial byte never reaches the register port.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        LVL_HIGH = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_SCL  = 2'd2,
        LVL_SDA  = 2'd3
    } strap_lvl_e;

endpackage

// File: rtl/i2cbr_sync_det.sv
module i2cbr_sync_det #(
    parameter int SYNC_STAGES = 2,
    parameter int NPIN        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [NPIN-1:0] strap_i,
    output logic            scl_s,
    output logic            sda_s,
    output logic [NPIN-1:0] strap_s,
    output logic            scl_rise,
    output logic            scl_fall,
    output logic            start_det,
    output logic            stop_det
);
    localparam int W = NPIN + 2;

    logic [W-1:0] stg [SYNC_STAGES];
    logic         scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            stg[0] <= {strap_i, sda_i, scl_i};
            for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s   = stg[SYNC_STAGES-1][0];
    assign sda_s   = stg[SYNC_STAGES-1][1];
    assign strap_s = stg[SYNC_STAGES-1][W-1:2];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cbr_strap_dec.sv
module i2cbr_strap_dec
    import i2cbr_pkg::*;
#(
    parameter int NPIN        = 2,
    parameter int WARM_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   strap_s,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic [2*NPIN-1:0] lvl_codes
);
    localparam int CW = $clog2(WARM_CYCLES + 1);

    logic [CW-1:0] warm_q;
    logic          live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm_q <= '0;
        else if (!live)       warm_q <= warm_q + 1'b1;
    end
    assign live = (warm_q == CW'(WARM_CYCLES));

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic ne_hi, ne_lo, ne_scl, ne_sda;
        strap_lvl_e code;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ne_hi  <= 1'b0;
                ne_lo  <= 1'b0;
                ne_scl <= 1'b0;
                ne_sda <= 1'b0;
            end else if (live) begin
                if (strap_s[p] != 1'b1)  ne_hi  <= 1'b1;
                if (strap_s[p] != 1'b0)  ne_lo  <= 1'b1;
                if (strap_s[p] != scl_s) ne_scl <= 1'b1;
                if (strap_s[p] != sda_s) ne_sda <= 1'b1;
            end
        end

        always_comb begin
            if (!ne_hi)       code = LVL_HIGH;
            else if (!ne_lo)  code = LVL_LOW;
            else if (!ne_scl) code = LVL_SCL;
            else              code = LVL_SDA;
        end

        assign lvl_codes[2*p +: 2] = code;
    end

endmodule

// File: rtl/i2cbr_fsm.sv
module i2cbr_fsm
    import i2cbr_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CHW  = 2,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            sda_s,
    input  logic [DW-2:0]   my_addr,
    input  logic [DW-1:0]   reg_rdata,
    output logic            sda_oe,
    output logic [CHW-1:0]  reg_chan,
    output logic [IDXW-1:0] reg_idx,
    output logic [DW-1:0]   reg_wdata,
    output logic            reg_wr,
    output logic            reg_rd,
    output bus_state_e      state
);
    localparam int BCW   = $clog2(DW + 1);
    localparam int SUBW  = CHW + IDXW;
    localparam logic [BCW-1:0] LAST = BCW'(DW);

    bus_state_e          state_q, state_d;
    logic [BCW-1:0]      bitcnt_q;
    logic [DW-1:0]       shreg_q;
    logic [SUBW-1:0]     sub_q;
    logic [DW-1:0]       wdata_q;
    logic                drv_q, rw_q, more_q, wr_q, rd_q;
    logic                byte_done, addr_hit;

    assign byte_done = scl_fall && (bitcnt_q == LAST);
    assign addr_hit  = (shreg_q[DW-1:1] == my_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_SUB;
                ST_SUB:       if (byte_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK:   if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = more_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            sub_q    <= '0;
            wdata_q  <= '0;
            drv_q    <= 1'b0;
            rw_q     <= 1'b0;
            more_q   <= 1'b0;
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt_q <= '0;
                drv_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[DW-2:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    drv_q <= 1'b1;
                                    rw_q  <= shreg_q[0];
                                end
                            end else if (state_q == ST_SUB) begin
                                sub_q <= shreg_q[SUBW:1];
                                drv_q <= 1'b1;
                            end else begin
                                wdata_q <= shreg_q;
                                wr_q    <= 1'b1;
                                drv_q   <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise && rw_q) rd_q <= 1'b1;
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                shreg_q <= reg_rdata;
                                drv_q   <= ~reg_rdata[DW-1];
                            end else begin
                                drv_q   <= 1'b0;
                            end
                        end
                    end
                    ST_SUB_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            drv_q    <= 1'b0;
                            bitcnt_q <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                        if (scl_fall) begin
                            if (bitcnt_q == LAST) begin
                                drv_q <= 1'b0;
                            end else begin
                                shreg_q <= {shreg_q[DW-2:0], 1'b0};
                                drv_q   <= ~shreg_q[DW-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            more_q <= ~sda_s;
                            if (!sda_s) rd_q <= 1'b1;
                        end
                        if (scl_fall && more_q) begin
                            bitcnt_q <= '0;
                            shreg_q  <= reg_rdata;
                            drv_q    <= ~reg_rdata[DW-1];
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        drv_q    <= 1'b0;
                        bitcnt_q <= '0;
                    end
                    default: drv_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe    = drv_q;
    assign reg_chan  = sub_q[CHW-1:0];
    assign reg_idx   = sub_q[SUBW-1:CHW];
    assign reg_wdata = wdata_q;
    assign reg_wr    = wr_q;
    assign reg_rd    = rd_q;
    assign state     = state_q;

endmodule

// File: rtl/i2c_regbridge.sv
module i2c_regbridge
    import i2cbr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_BASE   = 7'h48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_oe,
    output logic [1:0] reg_chan,
    output logic [3:0] reg_idx,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata
);
    localparam int NPIN = 2;
    localparam int WARM = SYNC_STAGES + 1;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [NPIN-1:0]  strap_s;
    logic [2*NPIN-1:0] lvl_codes;
    logic [6:0]       my_addr;
    bus_state_e       fsm_state;

    i2cbr_sync_det #(.SYNC_STAGES(SYNC_STAGES), .NPIN(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap_i),
        .scl_s(scl_s), .sda_s(sda_s), .strap_s(strap_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cbr_strap_dec #(.NPIN(NPIN), .WARM_CYCLES(WARM)) u_strap (
        .clk(clk), .rst_n(rst_n), .strap_s(strap_s), .scl_s(scl_s), .sda_s(sda_s),
        .lvl_codes(lvl_codes)
    );

    assign my_addr = ADDR_BASE + 7'(lvl_codes);

    i2cbr_fsm #(.DW(8), .CHW(2), .IDXW(4)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .my_addr(my_addr), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
        .reg_chan(reg_chan), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .state(fsm_state)
    );

endmodule

// File: rtl/i2cbr_chk.sv
module i2cbr_chk
    import i2cbr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input bus_state_e state
);
    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !reg_wr && !reg_rd));

    assert_wr_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !scl_s);

endmodule

bind i2c_regbridge i2cbr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .state(fsm_state)
);

// File: tb/i2c_regbridge_tb.sv
module i2c_regbridge_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] code1 = 2'd0, code0 = 2'd0;
    logic       sda_bus;
    logic [1:0] strap_w;
    logic       sda_oe, reg_wr, reg_rd;
    logic [1:0] reg_chan;
    logic [3:0] reg_idx;
    logic [7:0] reg_wdata, reg_rdata;

    int compared = 0, mismatched = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [1:0] last_chan;
    logic [3:0] last_idx;
    logic [7:0] last_data;
    logic [7:0] mem [64];
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic lvl(input logic [1:0] c, input logic s, input logic d);
        case (c)
            2'd0: lvl = 1'b1;
            2'd1: lvl = 1'b0;
            2'd2: lvl = s;
            default: lvl = d;
        endcase
    endfunction

    assign sda_bus = sda_m & ~sda_oe;
    assign strap_w = {lvl(code1, scl_m, sda_bus), lvl(code0, scl_m, sda_bus)};
    assign reg_rdata = mem[{reg_chan, reg_idx}];

    i2c_regbridge u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap_w),
        .sda_oe(sda_oe), .reg_chan(reg_chan), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt    <= wr_cnt + 1;
            last_chan <= reg_chan;
            last_idx  <= reg_idx;
            last_data <= reg_wdata;
            mem[{reg_chan, reg_idx}] <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; cyc(Q); scl_m = 1'b1; cyc(Q); scl_m = 1'b0; cyc(Q);
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q/2); b = sda_bus; cyc(Q/2);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q); sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; cyc(Q); scl_m = 1'b1; cyc(Q); sda_m = 1'b1; cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(b);
        acked = ~b;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; cyc(4);
        rst_n = 1'b1; cyc(20);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int w0, r0;
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 13 + 5);
        cyc(2);
        // R9: outputs quiet while reset is held
        chk(!sda_oe && !reg_wr && !reg_rd, "R9 reset", {sda_oe, reg_wr, reg_rd}, 0);
        do_reset();
        chk(!sda_oe, "R9 after reset", sda_oe, 0);

        for (int cfg = 0; cfg < 16; cfg++) begin
            logic [6:0] addr, bad;
            logic [1:0] ch;
            logic [3:0] idx;
            logic [7:0] sub, d1, d2;
            code1 = 2'(cfg >> 2); code0 = 2'(cfg & 3);
            do_reset();
            addr = 7'(8'h48 + cfg);
            bad  = 7'(8'h48 + ((cfg + 5) & 15));
            ch   = 2'(cfg);
            idx  = 4'(cfg) ^ 4'h9;
            sub  = {cfg[2], idx, ch, cfg[0]};
            d1   = 8'(cfg * 7 + 1);
            d2   = 8'(cfg * 7 + 2);

            // R1 R2 R4 R5: write burst
            w0 = wr_cnt;
            do_start();
            send_byte({addr, 1'b0}, ack);
            chk(ack, "R1 R2 address ack", ack, 1);
            send_byte(sub, ack);
            chk(ack, "R4 subaddress ack", ack, 1);
            send_byte(d1, ack);
            chk(ack, "R5 data1 ack", ack, 1);
            send_byte(d2, ack);
            chk(ack, "R5 data2 ack", ack, 1);
            do_stop();
            chk(wr_cnt - w0 == 2, "R5 strobe count", wr_cnt - w0, 2);
            chk(last_chan == ch, "R4 channel", last_chan, ch);
            chk(last_idx == idx, "R4 index", last_idx, idx);
            chk(last_data == d2, "R5 data", last_data, d2);

            // R3: wrong address
            w0 = wr_cnt; r0 = rd_cnt;
            do_start();
            send_byte({bad, 1'b0}, ack);
            chk(!ack, "R3 mismatch nack", ack, 0);
            send_byte(8'h00, ack);
            chk(!ack, "R3 ignored byte nack", ack, 0);
            do_stop();
            chk(wr_cnt == w0 && rd_cnt == r0, "R3 no strobes", wr_cnt - w0, 0);

            // R6 R7: read burst via repeated start
            r0 = rd_cnt;
            do_start();
            send_byte({addr, 1'b0}, ack);
            send_byte(sub, ack);
            do_start();
            send_byte({addr, 1'b1}, ack);
            chk(ack, "R6 read address ack", ack, 1);
            for (int k = 0; k < 3; k++) begin
                read_byte(k < 2, v);
                chk(v == d2, "R6 read data", v, d2);
            end
            read_bit(ack);
            chk(ack == 1'b1, "R7 released after nack", ack, 1);
            do_stop();
            chk(rd_cnt - r0 == 3, "R7 read strobe count", rd_cnt - r0, 3);
        end

        // R8: START and STOP inside a data byte
        code1 = 2'd0; code0 = 2'd0;
        do_reset();
        w0 = wr_cnt;
        do_start();
        send_byte(8'h90, ack);
        chk(ack, "R1 default address 0x90", ack, 1);
        send_byte(8'h08, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_start();
        chk(wr_cnt == w0, "R8 start aborts byte", wr_cnt - w0, 0);
        send_byte(8'h90, ack);
        chk(ack, "R8 readdressed after abort", ack, 1);
        send_byte(8'h08, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        do_stop();
        chk(wr_cnt == w0, "R8 stop aborts byte", wr_cnt - w0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule